// File: doc/BRIEF.md
# Iterative Count-Parity Matrix Decoder

This block decodes one protected block of 105 data bits laid out as an 8 x 19 bit matrix. Each of the first seven rows holds 15 data bits and a 4-bit field that gives how many of those data bits are one. The eighth row holds even parity for all 19 columns. The decoder flags failing columns and failing rows. For each failing row it records the signed gap between the stored count and the count it measured. An iterative loop then uses the sign and size of that gap to decide which bits to flip where the row crosses a failing column.

A whole matrix is taken in one transfer with a valid/ready handshake. The decoder then works through the rows, one per clock, in repeated passes. When it finishes it presents the 105 data bits for one cycle, together with either an accept flag or a retransmit-request flag. The caller uses the retransmit flag to ask for the block again. The decoder takes a new block only after the current one has been presented.

Top module: `cpm_decoder`

## Requirements
- R1: A column is in the failing set when the XOR of all 8 of its bits is 1. Two errors that cancel in a row's count but leave two failing columns cannot be resolved and end in a retransmit request.
- R2: For data row r, the data field is `in_rows[r*19 +: 15]` and the count field is the unsigned value `in_rows[r*19+15 +: 4]`. The row fails when its difference (count field minus ones in the data field) is nonzero. A single flipped data bit is corrected and the block accepted.
- R3: Row 7 (`in_rows[133 +: 19]`) is the parity row and is never treated as a failing row. An error confined to it gives a retransmit request with the data output equal to the received data.
- R4: A block with no failing row and no failing column is accepted with its data unchanged. `out_valid` rises 7 cycles after the handshake edge (one clean pass).
- R5: A data bit that counts as a match is one lying in a failing column that is 0 when the difference is positive, or 1 when it is negative. A 0-to-1 error is therefore corrected.
- R6: When the number of matches in a failing row equals the absolute difference, every matched bit is inverted. Their columns leave the failing-column set and the row leaves the failing-row set. Two errors in one row are corrected this way.
- R7: Rows are visited in order 0 to 6, one per cycle, in passes. A new pass starts only if the previous pass changed something, up to at most 7 passes. A row skipped in an earlier pass is corrected in a later pass once another row has cleared a column. `out_valid` rises 7 x (passes) cycles after the handshake.
- R8: Only data columns 0..14 may be inverted. A failing count column (15..18) is never cleared and leads to a retransmit request.
- R9: After reset `in_ready` is 1 and `out_valid`, `out_accept`, `out_retx` are 0. `in_ready` is 0 from the handshake until the result has been presented. `out_valid` lasts exactly one cycle. `out_accept` and `out_retx` are high only with `out_valid`, and exactly one of them is high.
- R10: `out_data[r*15 +: 15]` carries the (possibly corrected) data field of row r. `out_accept` is 1 only when no failing row and no failing column remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input matrix is valid |
| in_ready | output | 1 | Decoder can take a matrix |
| in_rows | input | 152 | Eight 19-bit rows, row r at bits r*19 upward |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 105 | Seven 15-bit data fields, row r at bits r*15 upward |
| out_accept | output | 1 | Block is clean or fully corrected |
| out_retx | output | 1 | Errors remain, retransmission requested |

## Verification
The hardest situation to reach from the ports is a block that needs the cyclic revisit. In such a block, an earlier row has more matches than its difference until a later row clears one of the shared columns. The bench builds this on purpose: one row has a 1-to-0 error in one column and a genuine 0 in a second failing column, and the second column's error sits in a later row. This forces a second changing pass and a third clean pass. The reference model predicts the number of passes, so the bench also checks the exact cycle of `out_valid` for every block, including random multi-error blocks.

// File: rtl/cpm_pkg.sv
// Shared constants and the state encoding of the count-parity matrix decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package cpm_pkg;
    localparam int DEF_DATA_ROWS  = 7;
    localparam int DEF_DATA_COLS  = 15;
    localparam int DEF_MAX_PASSES = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } dec_state_e;
endpackage

// File: rtl/cpm_syndrome.sv
// Computes the failing-column set, the failing-row set and the signed
// per-row difference (stored count minus counted ones) of a full matrix.
// Assumes: rows packed LSB-first, data field in the low DATA_COLS bits of a
// row and the count field above it; the last row holds column parity only.
module cpm_syndrome #(
    parameter int DATA_ROWS = 7,
    parameter int DATA_COLS = 15,
    localparam int CNT_W  = $clog2(DATA_COLS + 1),
    localparam int ROW_W  = DATA_COLS + CNT_W,
    localparam int MAT_W  = (DATA_ROWS + 1) * ROW_W,
    localparam int DIFF_W = CNT_W + 1
) (
    input  logic [MAT_W-1:0]            mat_i,
    output logic [ROW_W-1:0]            col_err_o,
    output logic [DATA_ROWS-1:0]        row_err_o,
    output logic [DATA_ROWS*DIFF_W-1:0] diff_o
);
    // Column parity across all rows, parity row included.
    for (genvar c = 0; c < ROW_W; c++) begin : g_col
        always_comb begin
            col_err_o[c] = 1'b0;
            for (int r = 0; r <= DATA_ROWS; r++) begin
                col_err_o[c] = col_err_o[c] ^ mat_i[r*ROW_W + c];
            end
        end
    end

    // Per data row: count ones, subtract from stored count.
    for (genvar r = 0; r < DATA_ROWS; r++) begin : g_row
        logic [CNT_W-1:0]         ones;
        logic [CNT_W-1:0]         stored;
        logic signed [DIFF_W-1:0] diff;

        always_comb begin
            ones = '0;
            for (int c = 0; c < DATA_COLS; c++) begin
                ones = ones + CNT_W'(mat_i[r*ROW_W + c]);
            end
        end

        assign stored = mat_i[r*ROW_W + DATA_COLS +: CNT_W];
        assign diff   = $signed({1'b0, stored}) - $signed({1'b0, ones});
        assign diff_o[r*DIFF_W +: DIFF_W] = diff;
        assign row_err_o[r] = (diff != '0);
    end
endmodule

// File: rtl/cpm_row_fix.sv
// Match-and-invert decision for one failing row: finds data bits in failing
// columns whose value points the way the sign of the difference demands and
// reports a fix when their number equals the magnitude of the difference.
// Assumes: diff_i is the row's signed difference, cand_i the failing data columns.
module cpm_row_fix #(
    parameter int DATA_COLS = 15,
    parameter int DIFF_W    = 5
) (
    input  logic [DATA_COLS-1:0]     data_i,
    input  logic signed [DIFF_W-1:0] diff_i,
    input  logic [DATA_COLS-1:0]     cand_i,
    output logic                     hit_o,
    output logic [DATA_COLS-1:0]     flip_o
);
    logic                 neg;
    logic [DATA_COLS-1:0] match;
    logic [DIFF_W-1:0]    n_match;
    logic [DIFF_W-1:0]    mag;

    // Matches: zeros for a positive difference, ones for a negative one.
    assign neg   = diff_i[DIFF_W-1];
    assign match = cand_i & (neg ? data_i : ~data_i);

    // Population count of the matches.
    always_comb begin
        n_match = '0;
        for (int c = 0; c < DATA_COLS; c++) begin
            n_match = n_match + DIFF_W'(match[c]);
        end
    end

    assign mag    = neg ? DIFF_W'(-diff_i) : DIFF_W'(diff_i);
    assign hit_o  = (diff_i != '0) && (n_match == mag);
    assign flip_o = hit_o ? match : '0;
endmodule

// File: rtl/cpm_decoder.sv
// Iterative count-parity matrix decoder. Captures a full matrix on a
// valid/ready handshake, records failing columns and rows, then scans the data
// rows one per clock in passes, inverting bits per the match rule, until a
// pass makes no change or MAX_PASSES passes have run. Presents the data for
// one cycle with accept or retransmit-request.
// Assumes: in_valid is only acted upon while in_ready is high.
module cpm_decoder
    import cpm_pkg::*;
#(
    parameter int DATA_ROWS  = DEF_DATA_ROWS,
    parameter int DATA_COLS  = DEF_DATA_COLS,
    parameter int MAX_PASSES = DEF_MAX_PASSES,
    localparam int CNT_W  = $clog2(DATA_COLS + 1),
    localparam int ROW_W  = DATA_COLS + CNT_W,
    localparam int MAT_W  = (DATA_ROWS + 1) * ROW_W,
    localparam int OUT_W  = DATA_ROWS * DATA_COLS,
    localparam int DIFF_W = CNT_W + 1,
    localparam int IDX_W  = (DATA_ROWS > 1) ? $clog2(DATA_ROWS) : 1,
    localparam int PASS_W = $clog2(MAX_PASSES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [MAT_W-1:0] in_rows,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             out_accept,
    output logic             out_retx
);
    dec_state_e               state_q;
    logic [DATA_COLS-1:0]     data_q [DATA_ROWS];
    logic signed [DIFF_W-1:0] diff_q [DATA_ROWS];
    logic [ROW_W-1:0]         col_q;
    logic [DATA_ROWS-1:0]     row_q;
    logic [IDX_W-1:0]         idx_q;
    logic [PASS_W-1:0]        pass_q;
    logic                     changed_q;

    logic [ROW_W-1:0]            syn_col;
    logic [DATA_ROWS-1:0]        syn_row;
    logic [DATA_ROWS*DIFF_W-1:0] syn_diff;
    logic                        fix_hit;
    logic [DATA_COLS-1:0]        fix_flip;
    logic                        fix_en;
    logic                        pass_chg;
    logic                        last_row;
    logic                        take;

    // Syndrome of the incoming matrix, latched on the handshake.
    cpm_syndrome #(.DATA_ROWS(DATA_ROWS), .DATA_COLS(DATA_COLS)) i_syn (
        .mat_i     (in_rows),
        .col_err_o (syn_col),
        .row_err_o (syn_row),
        .diff_o    (syn_diff)
    );

    // Match-and-invert decision for the row under the scan pointer.
    cpm_row_fix #(.DATA_COLS(DATA_COLS), .DIFF_W(DIFF_W)) i_fix (
        .data_i (data_q[idx_q]),
        .diff_i (diff_q[idx_q]),
        .cand_i (col_q[DATA_COLS-1:0]),
        .hit_o  (fix_hit),
        .flip_o (fix_flip)
    );

    // Scan control terms.
    assign take     = in_valid && in_ready;
    assign fix_en   = (state_q == ST_SCAN) && row_q[idx_q] && fix_hit;
    assign pass_chg = changed_q || fix_en;
    assign last_row = (idx_q == IDX_W'(DATA_ROWS - 1));

    // Sequencer: capture, scan rows in passes, present result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            col_q     <= '0;
            row_q     <= '0;
            idx_q     <= '0;
            pass_q    <= '0;
            changed_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (take) begin
                    state_q   <= ST_SCAN;
                    col_q     <= syn_col;
                    row_q     <= syn_row;
                    idx_q     <= '0;
                    pass_q    <= '0;
                    changed_q <= 1'b0;
                end
                ST_SCAN: begin
                    if (fix_en) begin
                        col_q[DATA_COLS-1:0] <= col_q[DATA_COLS-1:0] & ~fix_flip;
                        row_q[idx_q]         <= 1'b0;
                    end
                    if (last_row) begin
                        idx_q     <= '0;
                        changed_q <= 1'b0;
                        if (!pass_chg || pass_q == PASS_W'(MAX_PASSES - 1)) begin
                            state_q <= ST_DONE;
                        end else begin
                            pass_q <= pass_q + 1'b1;
                        end
                    end else begin
                        idx_q     <= idx_q + 1'b1;
                        changed_q <= pass_chg;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Data matrix storage: loaded on capture, bits inverted on a fix.
    always_ff @(posedge clk) begin
        for (int r = 0; r < DATA_ROWS; r++) begin
            if (state_q == ST_IDLE && take) begin
                data_q[r] <= in_rows[r*ROW_W +: DATA_COLS];
                diff_q[r] <= syn_diff[r*DIFF_W +: DIFF_W];
            end else if (fix_en && idx_q == IDX_W'(r)) begin
                data_q[r] <= data_q[r] ^ fix_flip;
            end
        end
    end

    // Output mapping.
    for (genvar r = 0; r < DATA_ROWS; r++) begin : g_out
        assign out_data[r*DATA_COLS +: DATA_COLS] = data_q[r];
    end

    assign in_ready   = (state_q == ST_IDLE);
    assign out_valid  = (state_q == ST_DONE);
    assign out_accept = out_valid && (row_q == '0) && (col_q == '0);
    assign out_retx   = out_valid && !((row_q == '0) && (col_q == '0));

    // R9: exactly one verdict flag with each result strobe.
    a_r9_flag_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_accept ^ out_retx));

    // R9: the result strobe lasts a single cycle.
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7: the pass counter never exceeds the pass limit.
    a_r7_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> (pass_q < PASS_W'(MAX_PASSES)));

    // R6: while scanning, rows only ever leave the failing set.
    a_r6_rows_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |=> ((row_q & ~$past(row_q)) == '0));

    // R6/R8: columns only leave the failing set, count columns never do.
    a_r8_cols_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |=> ((col_q & ~$past(col_q)) == '0)
            && (col_q[ROW_W-1:DATA_COLS] == $past(col_q[ROW_W-1:DATA_COLS])));
endmodule

// File: tb/test_cpm_decoder.sv
// Self-checking bench: behavioural reference decoder predicts data, verdict
// and pass count; outputs are compared on every clock of each decode.
module test_cpm_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic         in_valid = 1'b0;
    logic [151:0] in_rows  = '0;
    logic         in_ready, out_valid, out_accept, out_retx;
    logic [104:0] out_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef logic [18:0] mat_t [8];
    typedef logic [14:0] dat_t [7];

    cpm_decoder i_cpm_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_rows(in_rows), .out_valid(out_valid), .out_data(out_data),
        .out_accept(out_accept), .out_retx(out_retx)
    );

    function automatic int ones15(logic [14:0] v);
        int n = 0;
        for (int i = 0; i < 15; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic mat_t encode(dat_t d);
        mat_t m;
        m[7] = '0;
        for (int r = 0; r < 7; r++) begin
            m[r] = {4'(ones15(d[r])), d[r]};
            m[7] = m[7] ^ m[r];
        end
        return m;
    endfunction

    function automatic logic [151:0] pack(mat_t m);
        logic [151:0] v;
        for (int r = 0; r < 8; r++) v[r*19 +: 19] = m[r];
        return v;
    endfunction

    // Reference decoder written from the requirements.
    task automatic model(input mat_t mi, output logic [104:0] od,
                         output bit acc, output int passes);
        mat_t m = mi;
        logic [18:0] ce = '0;
        logic [6:0]  re = '0;
        int df [7];
        bit chg;
        for (int c = 0; c < 19; c++)
            for (int r = 0; r < 8; r++) ce[c] = ce[c] ^ m[r][c];
        for (int r = 0; r < 7; r++) begin
            df[r] = int'(m[r][18:15]) - ones15(m[r][14:0]);
            re[r] = (df[r] != 0);
        end
        passes = 0;
        do begin
            passes++;
            chg = 0;
            for (int r = 0; r < 7; r++) begin
                if (re[r]) begin
                    int need = (df[r] < 0) ? -df[r] : df[r];
                    int got = 0;
                    logic [14:0] hm = '0;
                    for (int c = 0; c < 15; c++) begin
                        if (ce[c] && ((df[r] > 0 && !m[r][c]) || (df[r] < 0 && m[r][c]))) begin
                            got++;
                            hm[c] = 1'b1;
                        end
                    end
                    if (got == need) begin
                        m[r][14:0] = m[r][14:0] ^ hm;
                        ce[14:0] = ce[14:0] & ~hm;
                        re[r] = 1'b0;
                        chg = 1;
                    end
                end
            end
        end while (chg && passes < 7);
        acc = (re == '0) && (ce == '0);
        for (int r = 0; r < 7; r++) od[r*15 +: 15] = m[r][14:0];
    endtask

    task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Send one matrix and compare the outputs on every clock until the result.
    task automatic run_block(string req, mat_t m);
        logic [104:0] ed;
        bit acc;
        int p, lat;
        model(m, ed, acc, p);
        lat = 7 * p;
        @(negedge clk);
        check("R9", "in_ready before send", 128'(in_ready), 128'(1));
        in_rows  = pack(m);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            check(req, "out_valid timing", 128'(out_valid), 128'(k == lat));
            check("R9", "in_ready busy", 128'(in_ready), 128'(0));
            if (k == lat) begin
                check(req, "out_accept", 128'(out_accept), 128'(acc));
                check(req, "out_retx", 128'(out_retx), 128'(!acc));
                check(req, "out_data R10", 128'(out_data), 128'(ed));
            end else begin
                check("R9", "flags idle", 128'({out_accept, out_retx}), 128'(0));
            end
        end
        @(negedge clk);
        check("R9", "out_valid single", 128'(out_valid), 128'(0));
        check("R9", "in_ready after", 128'(in_ready), 128'(1));
    endtask

    function automatic dat_t rand_data();
        dat_t d;
        for (int r = 0; r < 7; r++) d[r] = 15'($urandom);
        return d;
    endfunction

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        dat_t d;
        mat_t m;
        void'($urandom(7));
        repeat (3) @(negedge clk);
        check("R9", "reset in_ready", 128'(in_ready), 128'(1));
        check("R9", "reset out flags", 128'({out_valid, out_accept, out_retx}), 128'(0));
        rst_n = 1'b1;

        // R4: clean block
        d = rand_data(); m = encode(d);
        run_block("R4", m);

        // R2: single 1->0 error
        d = rand_data(); d[2][9] = 1'b1; m = encode(d); m[2][9] = 1'b0;
        run_block("R2", m);

        // R5: single 0->1 error, negative difference
        d = rand_data(); d[6][14] = 1'b0; m = encode(d); m[6][14] = 1'b1;
        run_block("R5", m);

        // R6: two 1->0 errors in one row
        d = rand_data(); d[3][4] = 1'b1; d[3][9] = 1'b1; m = encode(d);
        m[3][4] = 1'b0; m[3][9] = 1'b0;
        run_block("R6", m);

        // R2: scattered errors in three rows and columns
        d = rand_data(); d[0][1] = 1'b1; d[2][7] = 1'b0; d[5][12] = 1'b1; m = encode(d);
        m[0][1] = 1'b0; m[2][7] = 1'b1; m[5][12] = 1'b0;
        run_block("R2", m);

        // R3: error only in the parity row
        d = rand_data(); m = encode(d); m[7][3] = ~m[7][3];
        run_block("R3", m);

        // R8: error in a count field
        d = rand_data(); m = encode(d); m[2][16] = ~m[2][16];
        run_block("R8", m);

        // R1: cancelling pair in one row
        d = rand_data(); d[4][2] = 1'b1; d[4][6] = 1'b0; m = encode(d);
        m[4][2] = 1'b0; m[4][6] = 1'b1;
        run_block("R1", m);

        // R7: cyclic revisit needed (row 0 resolvable only after row 1)
        d = rand_data();
        d[0][2] = 1'b1; d[0][5] = 1'b0; d[1][2] = 1'b1; d[1][5] = 1'b1;
        m = encode(d); m[0][2] = 1'b0; m[1][5] = 1'b0;
        run_block("R7", m);

        // R10: random multi-error blocks against the model
        for (int t = 0; t < 25; t++) begin
            int nf;
            d = rand_data(); m = encode(d);
            nf = int'($urandom % 4);
            for (int f = 0; f < nf; f++) begin
                int pos = int'($urandom % 152);
                m[pos / 19][pos % 19] = ~m[pos / 19][pos % 19];
            end
            run_block("R10", m);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule